// File: doc/BRIEF.md
# 64-bit Rotate and Swap Unit

This unit is one execution slot of a 64-bit integer pipeline. It turns a 64-bit operand right by an amount taken from one of three places, or rearranges its bytes and halfwords in one of three fixed patterns. Register-file reads, instruction decode and exception handling are done elsewhere. The decoder supplies the source operand, a second operand that holds the variable rotate amount, a 5-bit immediate and a 3-bit operation code, and pulses `in_valid` for each operation.

All three rotate forms share one right-rotate network. Only the source of the amount differs: the immediate, the immediate plus half the datapath width, or the low bits of the second operand. The three permutations are fixed wiring. The selected result is registered once, so `res_valid` marks the cycle in which `res_out` holds the answer.

Top module: `rot_swap_unit`

## Requirements
- R1: With `op_sel` = 0 the result is `src_a` rotated right by `imm_sh` (0 to 31). An immediate of 0 returns `src_a` unchanged.
- R2: With `op_sel` = 1 the result is `src_a` rotated right by 32 + `imm_sh`. An immediate of 0 exchanges the upper and lower 32-bit words and does not pass the operand through.
- R3: With `op_sel` = 2 the result is `src_a` rotated right by `shamt_b[5:0]`. Bits 63:6 of `shamt_b` have no effect, and a zero in bits 5:0 returns `src_a` unchanged.
- R4: With `op_sel` = 3, bits 31:0 of the result are `src_a[31:0]` with the two bytes of each halfword exchanged. Every bit of 63:32 equals result bit 31, and `src_a[63:32]` has no effect.
- R5: With `op_sel` = 4, byte k of the result is byte k XOR 1 of `src_a` for all eight bytes.
- R6: With `op_sel` = 5, halfword k of the result (bits 16k+15:16k) is halfword 3-k of `src_a`, so the four halfwords come out in reverse order.
- R7: With `op_sel` = 6 or 7 the result is zero.
- R8: `res_out` takes the result of the inputs present at a rising edge where `in_valid` is 1, and `res_valid` equals `in_valid` delayed by exactly one clock.
- R9: While `in_valid` is 0, `res_out` keeps its last value whatever the other inputs do.
- R10: A synchronous active-high `rst` clears `res_out` and `res_valid` at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 3 | Operation code (0 to 5 are defined) |
| src_a | input | 64 | Operand to be rotated or permuted |
| shamt_b | input | 64 | Second operand; its low 6 bits give the variable rotate amount |
| imm_sh | input | 5 | Immediate rotate amount |
| res_out | output | 64 | Registered result |
| res_valid | output | 1 | Result strobe, one clock after `in_valid` |

## Verification
The immediate forms are run over all 32 immediates and the variable form over all 64 amounts. Each runs on several operands whose words, halfwords and bytes all differ, so a wrong amount, a wrong direction or a missing 32 offset gives a different value. The variable amount is sent with noisy upper bits to show that only six bits are used. The permutations are run on operands with bit 23 set and cleared, which tests the sign fill in both directions, and with distinct upper words to show they are ignored. Unused codes, hold without a strobe and a mid-stream reset are each checked at the outputs.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
   typedef enum logic [2:0] {
      OP_ROT_IMM   = 3'd0,
      OP_ROT_HALF  = 3'd1,
      OP_ROT_VAR   = 3'd2,
      OP_BSWAP_W   = 3'd3,
      OP_BSWAP_D   = 3'd4,
      OP_HREV_D    = 3'd5
   } rsu_op_e;

   localparam int OP_W = 3;
endpackage

// File: rtl/rsu_amt_sel.sv
module rsu_amt_sel #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 5,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [rsu_pkg::OP_W-1:0] op,
   input  logic [IMM_W-1:0]         imm,
   input  logic [DATA_W-1:0]        amt_reg,
   output logic [AMT_W-1:0]         amt
);
   import rsu_pkg::*;

   localparam logic [AMT_W-1:0] HALF_AMT = AMT_W'(DATA_W / 2);

   logic [AMT_W-1:0] imm_ext;
   assign imm_ext = AMT_W'(imm);

   always_comb begin
      case (op)
         OP_ROT_IMM:  amt = imm_ext;
         OP_ROT_HALF: amt = HALF_AMT + imm_ext;
         OP_ROT_VAR:  amt = amt_reg[AMT_W-1:0];
         default:     amt = '0;
      endcase
   end
endmodule

// File: rtl/rsu_rotr.sv
module rsu_rotr #(
   parameter int DATA_W = 64,
   parameter bit LOG_BARREL = 1'b1,
   localparam int AMT_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [AMT_W-1:0]  amt,
   output logic [DATA_W-1:0] dout
);
   generate
      if (LOG_BARREL) begin : g_log
         logic [DATA_W-1:0] stg [AMT_W+1];
         assign stg[0] = din;
         for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            localparam int SH = 1 << s;
            assign stg[s+1] = amt[s] ? {stg[s][SH-1:0], stg[s][DATA_W-1:SH]}
                                     : stg[s];
         end
         assign dout = stg[AMT_W];
      end else begin : g_flat
         logic [2*DATA_W-1:0] dbl;
         assign dbl  = {din, din} >> amt;
         assign dout = dbl[DATA_W-1:0];
      end
   endgenerate
endmodule

// File: rtl/rsu_perm.sv
module rsu_perm #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] bsw_word,
   output logic [DATA_W-1:0] bsw_full,
   output logic [DATA_W-1:0] hw_rev
);
   localparam int NH = DATA_W / 16;

   generate
      for (genvar h = 0; h < NH; h++) begin : g_half
         assign bsw_full[16*h +: 16] = {din[16*h +: 8], din[16*h+8 +: 8]};
         assign hw_rev[16*h +: 16]   = din[16*(NH-1-h) +: 16];
      end
   endgenerate

   assign bsw_word = {{(DATA_W-32){bsw_full[31]}}, bsw_full[31:0]};
endmodule

// File: rtl/rot_swap_unit.sv
module rot_swap_unit #(
   parameter int DATA_W     = 64,
   parameter int IMM_W      = 5,
   parameter bit LOG_BARREL = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [rsu_pkg::OP_W-1:0] op_sel,
   input  logic [DATA_W-1:0]        src_a,
   input  logic [DATA_W-1:0]        shamt_b,
   input  logic [IMM_W-1:0]         imm_sh,
   output logic [DATA_W-1:0]        res_out,
   output logic                     res_valid
);
   import rsu_pkg::*;

   localparam int AMT_W = $clog2(DATA_W);

   generate
      if (DATA_W < 64 || (1 << AMT_W) != DATA_W) begin : g_bad_width
         $error("DATA_W must be a power of two of at least 64");
      end
      if (IMM_W >= AMT_W) begin : g_bad_imm
         $error("IMM_W must be narrower than the rotate amount");
      end
   endgenerate

   logic [AMT_W-1:0]  amt;
   logic [DATA_W-1:0] rot_res;
   logic [DATA_W-1:0] bsw_w_res;
   logic [DATA_W-1:0] bsw_d_res;
   logic [DATA_W-1:0] hrev_res;
   logic [DATA_W-1:0] nxt_res;

   rsu_amt_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) amt_i (
      .op      (op_sel),
      .imm     (imm_sh),
      .amt_reg (shamt_b),
      .amt     (amt)
   );

   rsu_rotr #(.DATA_W(DATA_W), .LOG_BARREL(LOG_BARREL)) rot_i (
      .din  (src_a),
      .amt  (amt),
      .dout (rot_res)
   );

   rsu_perm #(.DATA_W(DATA_W)) perm_i (
      .din      (src_a),
      .bsw_word (bsw_w_res),
      .bsw_full (bsw_d_res),
      .hw_rev   (hrev_res)
   );

   always_comb begin
      case (op_sel)
         OP_ROT_IMM, OP_ROT_HALF, OP_ROT_VAR: nxt_res = rot_res;
         OP_BSWAP_W:                          nxt_res = bsw_w_res;
         OP_BSWAP_D:                          nxt_res = bsw_d_res;
         OP_HREV_D:                           nxt_res = hrev_res;
         default:                             nxt_res = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res_out   <= '0;
         res_valid <= 1'b0;
      end else begin
         res_valid <= in_valid;
         if (in_valid) res_out <= nxt_res;
      end
   end
endmodule

// File: rtl/rot_swap_unit_chk.sv
module rot_swap_unit_chk #(
   parameter int DATA_W = 64,
   parameter int IMM_W  = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [2:0]        op_sel,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] shamt_b,
   input logic [IMM_W-1:0]  imm_sh,
   input logic [DATA_W-1:0] res_out,
   input logic              res_valid
);
   localparam int AMT_W = $clog2(DATA_W);
   localparam int HW    = DATA_W / 2;

   logic fire;
   assign fire = in_valid && !rst;

   AST_IMM_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) == 3'd0 && $past(imm_sh) == '0
      |-> res_out == $past(src_a)); // R1

   AST_HALF_SWAP: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) == 3'd1 && $past(imm_sh) == '0
      |-> res_out == {$past(src_a[HW-1:0]), $past(src_a[DATA_W-1:HW])}); // R2

   AST_VAR_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) == 3'd2 && $past(shamt_b[AMT_W-1:0]) == '0
      |-> res_out == $past(src_a)); // R3

   AST_WORD_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) == 3'd3
      |-> res_out[DATA_W-1:32] == {(DATA_W-32){res_out[31]}}); // R4

   AST_FULL_BYTE_SWAP: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) == 3'd4
      |-> res_out[7:0] == $past(src_a[15:8])); // R5

   AST_HALF_REVERSE: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) == 3'd5
      |-> res_out[15:0] == $past(src_a[DATA_W-1 -: 16])); // R6

   AST_BAD_OP_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(fire) && $past(op_sel) >= 3'd6
      |-> res_out == '0); // R7

   AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> res_valid == $past(in_valid)); // R8

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(in_valid) |-> $stable(res_out)); // R9
endmodule

bind rot_swap_unit rot_swap_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .src_a     (src_a),
   .shamt_b   (shamt_b),
   .imm_sh    (imm_sh),
   .res_out   (res_out),
   .res_valid (res_valid)
);

// File: tb/rot_swap_unit_tb_top.sv
`timescale 1ns/1ps
module rot_swap_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [2:0]  op_sel = '0;
   logic [63:0] src_a = '0;
   logic [63:0] shamt_b = '0;
   logic [4:0]  imm_sh = '0;
   logic [63:0] res_out;
   logic        res_valid;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   rot_swap_unit dut_i (
      .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
      .src_a(src_a), .shamt_b(shamt_b), .imm_sh(imm_sh),
      .res_out(res_out), .res_valid(res_valid)
   );

   function automatic logic [63:0] f_rotr(logic [63:0] x, int n);
      logic [63:0] r;
      for (int i = 0; i < 64; i++) r[i] = x[(i + n) % 64];
      return r;
   endfunction

   function automatic logic [63:0] f_bswd(logic [63:0] x);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*(k^1) +: 8] = x[8*k +: 8];
      return r;
   endfunction

   function automatic logic [63:0] f_bsww(logic [63:0] x);
      logic [63:0] t;
      t = f_bswd(x);
      return {{32{t[31]}}, t[31:0]};
   endfunction

   function automatic logic [63:0] f_hrev(logic [63:0] x);
      logic [63:0] r;
      for (int k = 0; k < 4; k++) r[16*(3-k) +: 16] = x[16*k +: 16];
      return r;
   endfunction

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(logic [2:0] op, logic [63:0] a, logic [63:0] b,
                         logic [4:0] im, logic [63:0] exp, string tag);
      @(negedge clk);
      op_sel = op; src_a = a; shamt_b = b; imm_sh = im; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(tag, res_out, exp);
      check("R8 valid", {63'd0, res_valid}, 64'd1);
   endtask

   logic [63:0] pats [4];

   initial begin
      pats[0] = 64'h0123_4567_89AB_CDEF;
      pats[1] = 64'hFEDC_BA98_7654_3210;
      pats[2] = 64'h8000_0000_0000_0001;
      pats[3] = 64'h5A3C_0F96_E1D2_7B48;

      repeat (3) @(negedge clk);
      check("R10 reset res", res_out, 64'd0);
      check("R10 reset valid", {63'd0, res_valid}, 64'd0);
      rst = 1'b0;

      for (int p = 0; p < 4; p++) begin
         for (int i = 0; i < 32; i++) begin
            run_op(3'd0, pats[p], ~pats[p], 5'(i), f_rotr(pats[p], i), "R1 rot imm");
            run_op(3'd1, pats[p], ~pats[p], 5'(i), f_rotr(pats[p], 32 + i), "R2 rot half");
         end
         for (int n = 0; n < 64; n++) begin
            logic [63:0] b;
            b = {pats[(p+1)%4][63:6] ^ 58'h2AA_AAAA_5555_5555, 6'(n)};
            run_op(3'd2, pats[p], b, 5'(n), f_rotr(pats[p], n), "R3 rot var");
         end
         run_op(3'd3, pats[p], 0, 0, f_bsww(pats[p]), "R4 word bswap");
         run_op(3'd3, {~pats[p][63:32], pats[p][31:0]}, 0, 0, f_bsww(pats[p]), "R4 upper ignored");
         run_op(3'd4, pats[p], 0, 0, f_bswd(pats[p]), "R5 full bswap");
         run_op(3'd5, pats[p], 0, 0, f_hrev(pats[p]), "R6 half reverse");
         run_op(3'd6, pats[p], pats[p], 5'd7, 64'd0, "R7 code 6");
         run_op(3'd7, pats[p], pats[p], 5'd7, 64'd0, "R7 code 7");
      end

      run_op(3'd3, 64'h0000_0000_0080_0000, 0, 0, 64'hFFFF_FFFF_8000_0000, "R4 sign one");
      run_op(3'd3, 64'hFFFF_FFFF_FF7F_FFFF, 0, 0, 64'h0000_0000_7FFF_FFFF, "R4 sign zero");

      run_op(3'd0, pats[0], 0, 5'd4, f_rotr(pats[0], 4), "R9 setup");
      @(negedge clk);
      op_sel = 3'd5; src_a = pats[1]; imm_sh = 5'd9;
      repeat (3) @(negedge clk);
      check("R9 hold", res_out, f_rotr(pats[0], 4));
      check("R8 idle valid", {63'd0, res_valid}, 64'd0);

      @(negedge clk);
      op_sel = 3'd4; src_a = pats[3]; in_valid = 1'b1;
      @(negedge clk);
      op_sel = 3'd5; src_a = pats[1];
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 back to back", res_out, f_hrev(pats[1]));
      check("R8 back to back valid", {63'd0, res_valid}, 64'd1);

      rst = 1'b1;
      @(negedge clk);
      check("R10 mid reset res", res_out, 64'd0);
      check("R10 mid reset valid", {63'd0, res_valid}, 64'd0);
      rst = 1'b0;

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule